// File: doc/BRIEF.md
# Real-Time Calendar Counter with Minute/Hour/Day Alarm

The block keeps time of day and an elapsed-day count from a one-cycle pulse that arrives once per second. Seconds, minutes and hours are held as two-digit BCD values. The day count is a plain binary counter. Software loads and reads each field through a small byte-wide register port. Each read returns its data one clock after the address is presented.

An alarm compares the running minute, hour and day against programmed values. Each of the three fields can be switched into or out of the comparison. The comparison is made once per minute, just after seconds roll over to 00. A hit sets a sticky flag that software clears by writing 1. The interrupt line is that flag gated by an interrupt enable.

Register addresses: 0 seconds, 1 minutes, 2 hours, 3 day bits [7:0], 4 day bits [14:8], 5 alarm minutes, 6 alarm hours, 7 alarm day bits [7:0], 8 alarm day bits [14:8], 9 control, 10 status. In the control register, bit 0 is the interrupt enable, bit 1 enables the minute match, bit 2 enables the hour match and bit 3 enables the day match. In the status register, bit 0 is the alarm flag. Unused bits and unused addresses read 0.

Top module: `rtc_cal_alarm`

## Requirements
- R1: After a synchronous reset, every time field, every alarm field, the control register and the alarm flag read 0, and `alarm_irq` is low.
- R2: On each `tick_1hz` pulse, seconds (address 0) advance in BCD (0x09 becomes 0x10). The step after 0x59 is 0x00, and that step carries one into minutes.
- R3: Minutes (address 1) count in BCD from 0x00 to 0x59. The step after 0x59 is 0x00, and that step carries into hours.
- R4: Hours (address 2) count in BCD from 0x00 to 0x23. The step after 0x23 is 0x00, and that step carries into the day count.
- R5: The day count is a 15-bit binary value. Bits [7:0] are at address 3 and bits [14:8] are at address 4, where bit 7 reads 0. The count wraps from 0x7FFF to 0 with no other effect.
- R6: A register write takes effect at the next clock edge. `rdata` shows the addressed register one clock after the address is presented. Writing a time field never produces a carry. A time-field write in the same cycle as a tick takes priority, and no field advances in that cycle.
- R7: The alarm is evaluated only on the rollover of seconds to 00. The flag (status bit 0) is set one clock after that rollover if at least one match enable is set and every enabled field equals its alarm register. With no match enable set, the flag is never set.
- R8: A field whose match enable is 0 does not take part in the comparison.
- R9: The flag stays set until status bit 0 is written with 1. Writing 0 to the status register has no effect.
- R10: `alarm_irq` is high exactly when the flag is set and control bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| alarm_irq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The bench builds the block with its default 15-bit day width. Because every field can be loaded directly, each rollover is reached in a few ticks rather than by counting through real time. This covers the full cascade from 23:59:59 into the day count and the 0x7FFF to 0 day wrap. The alarm scenarios place the count one second before a minute boundary. They then vary the match enables, mismatch a single field, try a match that appears away from second 00, and exercise clearing the flag and gating the interrupt.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DLO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DHI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'd5;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'd6;
  localparam logic [ADDR_W-1:0] A_ADLO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ADHI  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int           W    = 7,
  parameter logic [W-1:0] MAXV = 'h59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam int TW = W - 4;

  logic [TW-1:0] tens_up;
  logic [W-1:0]  val_up;

  assign tens_up = val[W-1:4] + TW'(1);
  assign val_up  = (val[3:0] == 4'd9) ? {tens_up, 4'd0} : val + W'(1);
  assign wrap    = inc && (val == MAXV);

  always_ff @(posedge clk) begin
    if (rst)      val <= '0;
    else if (ld)  val <= ld_val;
    else if (inc) val <= (val == MAXV) ? '0 : val_up;
  end

  // R2
  field_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val == MAXV) |=> (val == '0));

  // R6
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(val));
endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       wdata,
  input  logic             inc,
  output logic [DAY_W-1:0] cnt
);
  localparam int HI_W = DAY_W - 8;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (ld_lo) cnt[7:0] <= wdata;
    else if (ld_hi) cnt[DAY_W-1:8] <= wdata[HI_W-1:0];
    else if (inc)   cnt <= cnt + DAY_W'(1);
  end

  // R5
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_lo && !ld_hi && (&cnt)) |=> (cnt == '0));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval,
  input  logic [MIN_W-1:0]  min_now,
  input  logic [HOUR_W-1:0] hour_now,
  input  logic [DAY_W-1:0]  day_now,
  input  logic [MIN_W-1:0]  min_set,
  input  logic [HOUR_W-1:0] hour_set,
  input  logic [DAY_W-1:0]  day_set,
  input  logic [2:0]        fld_en,
  input  logic              clr,
  output logic              flag
);
  logic m_ok, h_ok, d_ok, hit;

  assign m_ok = !fld_en[0] || (min_now  == min_set);
  assign h_ok = !fld_en[1] || (hour_now == hour_set);
  assign d_ok = !fld_en[2] || (day_now  == day_set);
  assign hit  = eval && (|fld_en) && m_ok && h_ok && d_ok;

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(eval));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              alarm_irq
);
  localparam int HI_W = DAY_W - 8;

  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  mins;
  logic [HOUR_W-1:0] hour;
  logic [DAY_W-1:0]  day;
  logic sec_wrap, min_wrap, hour_wrap;
  logic time_wr, tick_eff, eval_q, flag, clr;

  logic [MIN_W-1:0]  a_min;
  logic [HOUR_W-1:0] a_hour;
  logic [DAY_W-1:0]  a_day;
  logic              irq_en;
  logic [2:0]        fld_en;
  logic [DATA_W-1:0] rd_n;

  assign time_wr  = wr_en && (addr <= A_DHI);
  assign tick_eff = tick_1hz && !time_wr;
  assign clr      = wr_en && (addr == A_STAT) && wdata[0];

  rtc_bcd_field #(.W(SEC_W), .MAXV(7'h59)) u_sec (
    .clk(clk), .rst(rst), .ld(wr_en && addr == A_SEC), .ld_val(wdata[SEC_W-1:0]),
    .inc(tick_eff), .val(sec), .wrap(sec_wrap));

  rtc_bcd_field #(.W(MIN_W), .MAXV(7'h59)) u_min (
    .clk(clk), .rst(rst), .ld(wr_en && addr == A_MIN), .ld_val(wdata[MIN_W-1:0]),
    .inc(sec_wrap), .val(mins), .wrap(min_wrap));

  rtc_bcd_field #(.W(HOUR_W), .MAXV(6'h23)) u_hour (
    .clk(clk), .rst(rst), .ld(wr_en && addr == A_HOUR), .ld_val(wdata[HOUR_W-1:0]),
    .inc(min_wrap), .val(hour), .wrap(hour_wrap));

  rtc_day_counter #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst(rst), .ld_lo(wr_en && addr == A_DLO), .ld_hi(wr_en && addr == A_DHI),
    .wdata(wdata), .inc(hour_wrap), .cnt(day));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_min  <= '0;
      a_hour <= '0;
      a_day  <= '0;
      irq_en <= 1'b0;
      fld_en <= '0;
      eval_q <= 1'b0;
    end else begin
      eval_q <= sec_wrap;
      if (wr_en) begin
        case (addr)
          A_AMIN:  a_min  <= wdata[MIN_W-1:0];
          A_AHOUR: a_hour <= wdata[HOUR_W-1:0];
          A_ADLO:  a_day[7:0] <= wdata;
          A_ADHI:  a_day[DAY_W-1:8] <= wdata[HI_W-1:0];
          A_CTRL: begin
            irq_en <= wdata[0];
            fld_en <= wdata[3:1];
          end
          default: ;
        endcase
      end
    end
  end

  rtc_alarm_unit #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W)) u_alarm (
    .clk(clk), .rst(rst), .eval(eval_q),
    .min_now(mins), .hour_now(hour), .day_now(day),
    .min_set(a_min), .hour_set(a_hour), .day_set(a_day),
    .fld_en(fld_en), .clr(clr), .flag(flag));

  assign alarm_irq = flag && irq_en;

  always_comb begin
    rd_n = '0;
    case (addr)
      A_SEC:   rd_n[SEC_W-1:0]  = sec;
      A_MIN:   rd_n[MIN_W-1:0]  = mins;
      A_HOUR:  rd_n[HOUR_W-1:0] = hour;
      A_DLO:   rd_n             = day[7:0];
      A_DHI:   rd_n[HI_W-1:0]   = day[DAY_W-1:8];
      A_AMIN:  rd_n[MIN_W-1:0]  = a_min;
      A_AHOUR: rd_n[HOUR_W-1:0] = a_hour;
      A_ADLO:  rd_n             = a_day[7:0];
      A_ADHI:  rd_n[HI_W-1:0]   = a_day[DAY_W-1:8];
      A_CTRL:  rd_n[3:0]        = {fld_en, irq_en};
      A_STAT:  rd_n[0]          = flag;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R6
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_SEC) |=> (sec == $past(wdata[SEC_W-1:0])));

  // R6
  wr_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (time_wr && addr != A_MIN) |=> $stable(mins));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_irq |-> (flag && irq_en));
endmodule

// File: tb/rtc_cal_alarm_bench.sv
`timescale 1ns/1ps
module rtc_cal_alarm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rtc_cal_alarm u_rtc_cal_alarm (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick_once();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  // after the tick, one more edge lets the alarm evaluation register
  task automatic tick_settle();
    tick_once();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [14:0] d);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
    wr(4'd3, d[7:0]); wr(4'd4, {1'b0, d[14:8]});
  endtask

  task automatic set_alarm(logic [7:0] h, logic [7:0] m, logic [14:0] d, logic [7:0] ctrl);
    wr(4'd6, h); wr(4'd5, m);
    wr(4'd7, d[7:0]); wr(4'd8, {1'b0, d[14:8]});
    wr(4'd9, ctrl);
    wr(4'd10, 8'h01);
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 10; a++) rd_chk("R1 reset register", a[3:0], 8'h00);
    chk("R1 irq after reset", {7'd0, alarm_irq}, 8'h00);
  endtask

  task automatic t_seconds();
    set_time(8'h00, 8'h00, 8'h09, 15'd0);
    tick_once();
    rd_chk("R2 bcd digit carry", 4'd0, 8'h10);
    wr(4'd0, 8'h58);
    tick_once();
    rd_chk("R2 seconds 59", 4'd0, 8'h59);
    tick_once();
    rd_chk("R2 seconds wrap", 4'd0, 8'h00);
    rd_chk("R2 carry into minutes", 4'd1, 8'h01);
  endtask

  task automatic t_minutes_hours();
    set_time(8'h22, 8'h59, 8'h59, 15'd5);
    tick_once();
    rd_chk("R3 minutes wrap", 4'd1, 8'h00);
    rd_chk("R3 carry into hours", 4'd2, 8'h23);
    rd_chk("R3 day untouched", 4'd3, 8'h05);
  endtask

  task automatic t_day();
    set_time(8'h23, 8'h59, 8'h59, 15'h00FF);
    tick_once();
    rd_chk("R4 hours wrap", 4'd2, 8'h00);
    rd_chk("R4 day low byte", 4'd3, 8'h00);
    rd_chk("R5 day high byte", 4'd4, 8'h01);
  endtask

  task automatic t_day_wrap();
    set_time(8'h23, 8'h59, 8'h59, 15'h7FFF);
    rd_chk("R5 high byte bit7 zero", 4'd4, 8'h7F);
    tick_once();
    rd_chk("R5 day wrap low", 4'd3, 8'h00);
    rd_chk("R5 day wrap high", 4'd4, 8'h00);
  endtask

  task automatic t_write_rules();
    set_time(8'h10, 8'h20, 8'h30, 15'd0);
    wr(4'd0, 8'h59);
    rd_chk("R6 write sets seconds", 4'd0, 8'h59);
    rd_chk("R6 write gives no carry", 4'd1, 8'h20);
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wdata = 8'h12; tick_1hz = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
    rd_chk("R6 write beats tick", 4'd0, 8'h12);
    rd_chk("R6 no advance on write", 4'd1, 8'h20);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    // ctrl 0x0F: irq enable, minute/hour/day matching
    set_alarm(8'h03, 8'h05, 15'd2, 8'h0F);
    set_time(8'h03, 8'h04, 8'h59, 15'd2);
    rd_chk("R7 flag before match", 4'd10, 8'h00);
    tick_settle();
    rd_chk("R7 flag on match", 4'd10, 8'h01);
    chk("R10 irq with enable", {7'd0, alarm_irq}, 8'h01);
    wr(4'd10, 8'h00);
    rd_chk("R9 zero write ignored", 4'd10, 8'h01);
    wr(4'd9, 8'h0E);
    chk("R10 irq gated off", {7'd0, alarm_irq}, 8'h00);
    rd(4'd10, v);
    chk("R10 flag kept while gated", v, 8'h01);
    wr(4'd10, 8'h01);
    rd_chk("R9 one write clears", 4'd10, 8'h00);
  endtask

  task automatic t_alarm_mismatch();
    set_alarm(8'h03, 8'h05, 15'd2, 8'h0F);
    set_time(8'h03, 8'h04, 8'h59, 15'd3);
    tick_settle();
    rd_chk("R7 day mismatch no flag", 4'd10, 8'h00);
    // day match disabled: bit3 clear
    set_alarm(8'h03, 8'h05, 15'd2, 8'h07);
    set_time(8'h03, 8'h04, 8'h59, 15'd3);
    tick_settle();
    rd_chk("R8 disabled day ignored", 4'd10, 8'h01);
    // minute only, hour different
    set_alarm(8'h11, 8'h05, 15'd9, 8'h03);
    set_time(8'h03, 8'h04, 8'h59, 15'd3);
    tick_settle();
    rd_chk("R8 minute only match", 4'd10, 8'h01);
  endtask

  task automatic t_alarm_edges();
    // no match enables
    set_alarm(8'h03, 8'h05, 15'd2, 8'h01);
    set_time(8'h03, 8'h04, 8'h59, 15'd2);
    tick_settle();
    rd_chk("R7 no enable no flag", 4'd10, 8'h00);
    // fields match but seconds are not rolling to 00
    set_alarm(8'h03, 8'h05, 15'd2, 8'h0F);
    set_time(8'h03, 8'h05, 8'h10, 15'd2);
    tick_settle();
    rd_chk("R7 no eval off rollover", 4'd10, 8'h00);
    chk("R10 irq low without flag", {7'd0, alarm_irq}, 8'h00);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seconds();
    t_minutes_hours();
    t_day();
    t_day_wrap();
    t_write_rules();
    t_alarm();
    t_alarm_mismatch();
    t_alarm_edges();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule